// File: doc/BRIEF.md
# Virtual-to-Physical Page Translator with Reference Tracking

This block turns a 16-bit virtual address into a 16-bit physical address. Pages are 4 KiB. An internal table with 16 entries does the lookup. The upper four address bits pick an entry. Each entry holds a frame number, a valid flag and a reference flag. The lower twelve bits pass through unchanged. Software loads entries through a write port. A requester presents an address, and one cycle later it receives either the physical address or a page-fault indication.

Every translation that succeeds marks its entry as referenced. A clear input wipes all reference flags at once. A replacement agent can sample the full reference vector at any time to find pages that have not been touched since the last clear. When a clear lands in the same cycle as a reference, the reference is kept. When a table write lands in the same cycle as a reference to the same entry, the write's reset of the flag is kept.

Top module: `vpage_translator`

## Requirements
- R1: For a request to a valid entry, the response address is the entry's 4-bit frame number in bits 15:12, followed by the request's bits 11:0 unchanged, and the fault output is 0. For example, page 14 mapped to frame 3 turns 0xE12C into 0x312C.
- R2: `xl_rsp_valid` is 1 exactly in the cycle after a cycle with `xl_req` high, so back-to-back requests give back-to-back responses. In any cycle with `xl_rsp_valid` low, `xl_rsp_paddr` and `xl_rsp_fault` are 0.
- R3: For a request to an entry whose valid flag is 0, the response has `xl_rsp_fault` = 1 and `xl_rsp_paddr` = 0, and the request does not change that entry's reference flag.
- R4: A successful translation sets the selected entry's reference flag. The flag is visible on `ref_bits[page]` in the cycle after the request. Bit i of `ref_bits` belongs to entry i.
- R5: When `ref_clear` is high for one cycle, every reference flag is 0 in the next cycle, except for the cases covered by R6 and R7.
- R6: If `ref_clear` and a successful translation happen in the same cycle, the translated entry's flag ends up 1 and all other flags end up 0.
- R7: A table write (`map_we`) loads the entry's frame and valid flag and sets its reference flag to 0. The reset of the flag takes priority over a same-cycle reference to that entry. A translation in the same cycle as a write to its entry uses the entry's previous contents.
- R8: After reset, all entries are invalid, all reference flags are 0, and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Table entry write strobe |
| map_page | input | 4 | Entry (virtual page) being written |
| map_frame | input | 4 | Frame number to store |
| map_valid | input | 1 | Valid flag to store |
| xl_req | input | 1 | Translation request |
| xl_vaddr | input | 16 | Virtual address to translate |
| xl_rsp_valid | output | 1 | Response present this cycle |
| xl_rsp_fault | output | 1 | Response is a page fault |
| xl_rsp_paddr | output | 16 | Translated physical address, 0 on fault |
| ref_clear | input | 1 | Zero all reference flags |
| ref_bits | output | 16 | Reference flag of each entry |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. This covers the response to a request, the reference flag set by a hit, the flags wiped by a clear, and the loaded entry of a write. The bench drives inputs on the falling edge. It predicts the next state of its behavioural table, fault outcome and flags from the inputs of that cycle. It compares all four outputs two nanoseconds after the following rising edge. Collisions of clear, write and reference are staged deliberately in a single cycle, so that the priority order is checked on the edge where it is resolved.

// File: rtl/vpage_translator.sv
module vpage_translator #(
  parameter int PAGE_BITS   = 4,
  parameter int OFFSET_BITS = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             map_we,
  input  logic [PAGE_BITS-1:0]             map_page,
  input  logic [PAGE_BITS-1:0]             map_frame,
  input  logic                             map_valid,
  input  logic                             xl_req,
  input  logic [PAGE_BITS+OFFSET_BITS-1:0] xl_vaddr,
  output logic                             xl_rsp_valid,
  output logic                             xl_rsp_fault,
  output logic [PAGE_BITS+OFFSET_BITS-1:0] xl_rsp_paddr,
  input  logic                             ref_clear,
  output logic [(1<<PAGE_BITS)-1:0]        ref_bits
);
  localparam int ENTRIES = 1 << PAGE_BITS;
  localparam int ADDR_W  = PAGE_BITS + OFFSET_BITS;

  logic [PAGE_BITS-1:0] frame_q [ENTRIES];
  logic [ENTRIES-1:0]   vld_q;
  logic [ENTRIES-1:0]   ref_q;

  wire [PAGE_BITS-1:0]   vpn = xl_vaddr[ADDR_W-1:OFFSET_BITS];
  wire [OFFSET_BITS-1:0] off = xl_vaddr[OFFSET_BITS-1:0];
  wire                   hit = xl_req & vld_q[vpn];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    wire wr_here  = map_we && (map_page == PAGE_BITS'(i));
    wire hit_here = hit && (vpn == PAGE_BITS'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[i]   <= 1'b0;
        frame_q[i] <= '0;
      end else if (wr_here) begin
        vld_q[i]   <= map_valid;
        frame_q[i] <= map_frame;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          ref_q[i] <= 1'b0;
      else if (wr_here)    ref_q[i] <= 1'b0;
      else if (hit_here)   ref_q[i] <= 1'b1;
      else if (ref_clear)  ref_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_rsp_valid <= 1'b0;
      xl_rsp_fault <= 1'b0;
      xl_rsp_paddr <= '0;
    end else begin
      xl_rsp_valid <= xl_req;
      xl_rsp_fault <= xl_req & ~vld_q[vpn];
      xl_rsp_paddr <= hit ? {frame_q[vpn], off} : '0;
    end
  end

  assign ref_bits = ref_q;
endmodule

// File: rtl/vpage_translator_chk.sv
module vpage_translator_chk #(
  parameter int PAGE_BITS   = 4,
  parameter int OFFSET_BITS = 12
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             map_we,
  input logic [PAGE_BITS-1:0]             map_page,
  input logic                             xl_req,
  input logic [PAGE_BITS+OFFSET_BITS-1:0] xl_vaddr,
  input logic                             xl_rsp_valid,
  input logic                             xl_rsp_fault,
  input logic [PAGE_BITS+OFFSET_BITS-1:0] xl_rsp_paddr,
  input logic                             ref_clear,
  input logic [(1<<PAGE_BITS)-1:0]        ref_bits,
  input logic [(1<<PAGE_BITS)-1:0]        vld_q
);
  localparam int ADDR_W = PAGE_BITS + OFFSET_BITS;
  wire [PAGE_BITS-1:0] vpn   = xl_vaddr[ADDR_W-1:OFFSET_BITS];
  wire                 wr_vp = map_we && (map_page == vpn);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_rsp_valid); // R2
  AST_RSP_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> (!xl_rsp_valid && !xl_rsp_fault && xl_rsp_paddr == '0)); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && vld_q[vpn]) |=> (!xl_rsp_fault &&
      xl_rsp_paddr[OFFSET_BITS-1:0] == $past(xl_vaddr[OFFSET_BITS-1:0]))); // R1
  AST_FAULT_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !vld_q[vpn]) |=> (xl_rsp_fault && xl_rsp_paddr == '0)); // R3
  AST_FAULT_KEEPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !vld_q[vpn] && !ref_clear && !wr_vp)
      |=> ref_bits[$past(vpn)] == $past(ref_bits[vpn])); // R3
  AST_HIT_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && vld_q[vpn] && !wr_vp && !ref_clear) |=> ref_bits[$past(vpn)]); // R4
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clear && !xl_req && !map_we) |=> ref_bits == '0); // R5
  AST_REF_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clear && xl_req && vld_q[vpn] && !wr_vp)
      |=> $countones(ref_bits) == 1 && ref_bits[$past(vpn)]); // R6
  AST_WRITE_DROPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |=> !ref_bits[$past(map_page)]); // R7
endmodule

bind vpage_translator vpage_translator_chk #(
  .PAGE_BITS(PAGE_BITS), .OFFSET_BITS(OFFSET_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_page(map_page),
  .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_rsp_valid(xl_rsp_valid),
  .xl_rsp_fault(xl_rsp_fault), .xl_rsp_paddr(xl_rsp_paddr),
  .ref_clear(ref_clear), .ref_bits(ref_bits), .vld_q(vld_q)
);

// File: tb/test_vpage_translator.sv
`timescale 1ns/100ps
module test_vpage_translator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_we = 1'b0;
  logic [3:0]  map_page = '0;
  logic [3:0]  map_frame = '0;
  logic        map_valid = 1'b0;
  logic        xl_req = 1'b0;
  logic [15:0] xl_vaddr = '0;
  logic        ref_clear = 1'b0;
  logic        xl_rsp_valid, xl_rsp_fault;
  logic [15:0] xl_rsp_paddr;
  logic [15:0] ref_bits;

  int tests = 0;
  int fails = 0;
  bit [3:0]  m_frame [16];
  bit [15:0] m_valid = '0;
  bit [15:0] m_ref = '0;
  bit        e_rv = 1'b0, e_f = 1'b0;
  bit [15:0] e_pa = '0;

  always #2.5 clk = ~clk;

  vpage_translator i_vpage_translator (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_page(map_page),
    .map_frame(map_frame), .map_valid(map_valid), .xl_req(xl_req),
    .xl_vaddr(xl_vaddr), .xl_rsp_valid(xl_rsp_valid), .xl_rsp_fault(xl_rsp_fault),
    .xl_rsp_paddr(xl_rsp_paddr), .ref_clear(ref_clear), .ref_bits(ref_bits)
  );

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "rsp_valid", 16'(xl_rsp_valid), 16'(e_rv));
    chk(tag, "rsp_fault", 16'(xl_rsp_fault), 16'(e_f));
    chk(tag, "rsp_paddr", xl_rsp_paddr, e_pa);
    chk(tag, "ref_bits", ref_bits, m_ref);
  endtask

  task automatic cyc(string tag, bit we, bit [3:0] pg, bit [3:0] fr, bit vl,
                     bit rq, bit [15:0] va, bit clr);
    bit [3:0] vp;
    bit hit;
    bit [15:0] nref;
    @(negedge clk);
    map_we = we; map_page = pg; map_frame = fr; map_valid = vl;
    xl_req = rq; xl_vaddr = va; ref_clear = clr;
    vp = va[15:12];
    hit = rq && m_valid[vp];
    e_rv = rq;
    e_f = rq && !m_valid[vp];
    e_pa = hit ? {m_frame[vp], va[11:0]} : 16'h0;
    for (int i = 0; i < 16; i++) begin
      if (we && pg == 4'(i))        nref[i] = 1'b0;
      else if (hit && vp == 4'(i))  nref[i] = 1'b1;
      else if (clr)                 nref[i] = 1'b0;
      else                          nref[i] = m_ref[i];
    end
    m_ref = nref;
    if (we) begin m_frame[pg] = fr; m_valid[pg] = vl; end
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  task automatic wr(string tag, bit [3:0] pg, bit [3:0] fr, bit vl);
    cyc(tag, 1'b1, pg, fr, vl, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic xl(string tag, bit [15:0] va);
    cyc(tag, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, va, 1'b0);
  endtask

  task automatic idle(string tag);
    cyc(tag, 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0, 1'b0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_frame[i] = 4'h0;
    repeat (3) @(posedge clk);
    #2;
    compare("R8");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R8");

    wr("R7", 4'd14, 4'd3, 1'b1);
    wr("R7", 4'd3, 4'd10, 1'b1);
    wr("R7", 4'd10, 4'd5, 1'b1);
    wr("R7", 4'd7, 4'd15, 1'b1);
    idle("R7");

    xl("R1", 16'hE12C);
    chk("R1", "paddr E12C", xl_rsp_paddr, 16'h312C);
    xl("R1", 16'h3A9D);
    chk("R1", "paddr 3A9D", xl_rsp_paddr, 16'hAA9D);
    xl("R4", 16'hA9D9);
    xl("R4", 16'h7001);
    chk("R1", "paddr 7001", xl_rsp_paddr, 16'hF001);
    xl("R2", 16'hACA1);
    chk("R1", "paddr ACA1", xl_rsp_paddr, 16'h5CA1);
    idle("R2");
    chk("R4", "four pages referenced", ref_bits, 16'h4488);

    xl("R3", 16'h1234);
    chk("R3", "fault flag", 16'(xl_rsp_fault), 16'h1);
    chk("R3", "ref untouched", 16'(ref_bits[1]), 16'h0);
    wr("R3", 4'd5, 4'd9, 1'b0);
    xl("R3", 16'h5FFF);

    cyc("R5", 1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0, 1'b1);
    chk("R5", "all clear", ref_bits, 16'h0);

    xl("R6", 16'h3000);
    cyc("R6", 1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 16'hE000, 1'b1);
    chk("R6", "reference wins", ref_bits, 16'h4000);

    cyc("R7", 1'b1, 4'd14, 4'd8, 1'b1, 1'b1, 16'hE456, 1'b0);
    chk("R7", "old mapping used", xl_rsp_paddr, 16'h3456);
    chk("R7", "write resets ref", 16'(ref_bits[14]), 16'h0);
    xl("R7", 16'hE456);
    chk("R7", "new mapping", xl_rsp_paddr, 16'h8456);
    cyc("R7", 1'b1, 4'd7, 4'd15, 1'b0, 1'b1, 16'h7000, 1'b0);
    xl("R7", 16'h7000);
    chk("R7", "invalidated entry faults", 16'(xl_rsp_fault), 16'h1);

    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom;
      cyc("R1", (r[3:0] == 4'h0), 4'(r[7:4]), 4'(r[11:8]), r[12],
          (r[14:13] != 2'b00), 16'($urandom), (r[19:16] == 4'h0));
    end
    idle("R2");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule